// File: doc/BRIEF.md
# Programmable Clock Controller with Low-Power Gating

This block turns three free-running source clocks into three gated, divided output clocks. The sources are a fast internal oscillator, a second crystal clock and a slow low-frequency oscillator. The outputs are a main clock, a sub-main clock and an auxiliary clock. Each output has its own source choice and a divide ratio of 1, 2, 4 or 8. Both come from fields in byte-wide configuration registers on a simple peripheral bus, which has an address, a write strobe, write data and combinational read data.

Four power-control inputs form a mode code. A state machine in the bus clock domain decodes that code into one of six states:

- `PM_RUN`: everything runs.
- `PM_NAP`: the core clock is off.
- `PM_NAP_LEAN`: as `PM_NAP`, and the fast oscillator and its bias generator are also released when the sub-main clock does not use the fast oscillator.
- `PM_DOZE`: the main and sub-main clocks and the fast oscillator are off, and the bias generator is kept.
- `PM_DOZE_DEEP`: as `PM_DOZE`, with the bias generator also off.
- `PM_HALT`: every clock is off.

From any state, each bus clock edge moves the machine to the state the mode inputs encode at that edge. The states drive per-output run enables and three oscillator enable outputs.

Each output has a divider. The divider is a counter clocked by the selected source. It adopts a new ratio only at the end of a full output period. A run enable is captured by a latch that is open only while the divided clock is low, so stopping or restarting an output never cuts a pulse short.

Top module: `clkctl_unit`

## Requirements
- R1: Four registers are held at byte addresses 0x56 (oscillator tuning, reset 0x60), 0x57 (config A, reset 0x87), 0x58 (config B, reset 0x00) and 0x53 (config C, reset 0x05). A write takes effect at the bus clock edge, and a read returns the last value written.
- R2: A read of any other address returns 0x00. A write to any other address changes no register.
- R3: Config B bits 7:6 select the main clock source: 00 or 01 selects the fast oscillator, 10 selects the second crystal and 11 selects the slow oscillator.
- R4: Config B bits 5:4 set the main divide ratio: 00 is /1, 01 is /2, 10 is /4 and 11 is /8.
- R5: Config B bit 3 selects the sub-main source (0 for the fast oscillator, 1 for the second crystal). Bits 2:1 set its divide ratio with the R4 encoding.
- R6: Config A bits 5:4 set the auxiliary divide ratio with the R4 encoding. Config A bit 6 selects the auxiliary source (0 for the slow oscillator, 1 for the second crystal).
- R7: The mode state is decoded as follows. With core-off clear the state is PM_RUN. With core-off set, the state is PM_NAP, PM_NAP_LEAN, PM_DOZE or PM_DOZE_DEEP according to the bias-off and sub-off inputs (neither, bias-off only, sub-off only, both). With all four inputs set the state is PM_HALT. The main clock runs only in PM_RUN. The sub-main clock runs in PM_RUN, PM_NAP and PM_NAP_LEAN. The auxiliary clock runs in every state except PM_HALT.
- R8: The oscillator enables follow the state one bus clock after the mode inputs. In PM_RUN and PM_NAP, all three enables are 1. In PM_NAP_LEAN, the fast-oscillator and bias enables equal the inverse of config B bit 3. PM_DOZE gives fast 0 and bias 1. PM_DOZE_DEEP gives fast 0 and bias 0. The slow-oscillator enable is 0 only in PM_HALT.
- R9: A stopped output clock is held low with no pulses, and it resumes at its programmed period when its state allows it to run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and mode-decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pm_core_off | input | 1 | Mode input: stop the core clock |
| pm_bias_off | input | 1 | Mode input: release the bias generator |
| pm_sub_off | input | 1 | Mode input: stop sub-main clock and fast oscillator |
| pm_osc_off | input | 1 | Mode input: stop the slow oscillator |
| fast_osc_clk | input | 1 | Fast internal oscillator source |
| xtal2_clk | input | 1 | Second crystal source |
| slow_osc_clk | input | 1 | Slow low-frequency oscillator source |
| main_clk | output | 1 | Gated, divided main clock |
| sub_clk | output | 1 | Gated, divided sub-main clock |
| aux_clk | output | 1 | Gated, divided auxiliary clock |
| fast_osc_en | output | 1 | Fast oscillator enable |
| bias_gen_en | output | 1 | Bias generator enable |
| slow_osc_en | output | 1 | Slow oscillator enable |

## Verification
Each source clock runs at a distinct period (10 ns, 14 ns and 40 ns), so a measured output period identifies both the source and the ratio. The tests step each output through every source code and several ratios. Selecting /8 on the slow source and /4 on the crystal separates a wrong select from a wrong divider. Each mode code is applied in turn, with the sub-main source toggled in PM_NAP_LEAN. This separates the two bias-generator conditions and shows whether each output stops low without stray edges and restarts afterwards.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

    localparam int DIV_W  = 2;
    localparam int NUM_CH = 3;
    localparam int CH_MAIN = 0;
    localparam int CH_SUB  = 1;
    localparam int CH_AUX  = 2;

    localparam logic [7:0] ADR_TUNE = 8'h56;
    localparam logic [7:0] ADR_CFGA = 8'h57;
    localparam logic [7:0] ADR_CFGB = 8'h58;
    localparam logic [7:0] ADR_CFGC = 8'h53;

    localparam logic [7:0] RST_TUNE = 8'h60;
    localparam logic [7:0] RST_CFGA = 8'h87;
    localparam logic [7:0] RST_CFGB = 8'h00;
    localparam logic [7:0] RST_CFGC = 8'h05;

    typedef enum logic [2:0] {
        PM_RUN,
        PM_NAP,
        PM_NAP_LEAN,
        PM_DOZE,
        PM_DOZE_DEEP,
        PM_HALT
    } pm_state_t;

    typedef struct packed {
        logic run_main;
        logic run_sub;
        logic run_aux;
        logic fast_en;
        logic bias_en;
        logic slow_en;
    } pm_ctl_t;

    function automatic logic addr_mapped(input logic [7:0] a);
        return (a == ADR_TUNE) || (a == ADR_CFGA) ||
               (a == ADR_CFGB) || (a == ADR_CFGC);
    endfunction

endpackage

// File: rtl/clkctl_divgate.sv
`timescale 1ns/1ps
module clkctl_divgate #(
    parameter int DIV_W = 2
) (
    input  logic             rst_n,
    input  logic             src_clk,
    input  logic [DIV_W-1:0] div_code,
    input  logic             run_en,
    output logic             clk_out
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] code_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             tog;
    logic             pass_q;
    logic             div_clk;
    logic             gate_q;

    // half period minus one, in source cycles
    always_comb begin
        term = (CNT_W'(1) << (code_act - DIV_W'(1))) - CNT_W'(1);
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            code_act <= '0;
            cnt      <= '0;
            tog      <= 1'b0;
        end else if (code_act == '0) begin
            code_act <= div_code;
            cnt      <= '0;
            tog      <= 1'b0;
        end else if (cnt == term) begin
            cnt <= '0;
            tog <= ~tog;
            if (tog) begin
                code_act <= div_code;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // switch between pass-through and divided path while source is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b1;
        end else begin
            pass_q <= (code_act == '0);
        end
    end

    assign div_clk = pass_q ? src_clk : tog;

    always_latch begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (!div_clk) begin
            gate_q <= run_en;
        end
    end

    assign clk_out = div_clk & gate_q;

endmodule

// File: rtl/clkctl_pmode.sv
`timescale 1ns/1ps
module clkctl_pmode
    import clkctl_pkg::*;
(
    input  logic    pclk,
    input  logic    rst_n,
    input  logic    core_off,
    input  logic    bias_off,
    input  logic    sub_off,
    input  logic    osc_off,
    input  logic    sub_on_fast,
    output pm_ctl_t ctl
);
    pm_state_t state_q;
    pm_state_t state_d;

    always_comb begin
        if (!core_off) begin
            state_d = PM_RUN;
        end else if (bias_off && sub_off && osc_off) begin
            state_d = PM_HALT;
        end else if (!sub_off && !bias_off) begin
            state_d = PM_NAP;
        end else if (!sub_off) begin
            state_d = PM_NAP_LEAN;
        end else if (!bias_off) begin
            state_d = PM_DOZE;
        end else begin
            state_d = PM_DOZE_DEEP;
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            PM_RUN: begin
                ctl.run_main = 1'b1;
                ctl.run_sub  = 1'b1;
                ctl.run_aux  = 1'b1;
                ctl.fast_en  = 1'b1;
                ctl.bias_en  = 1'b1;
                ctl.slow_en  = 1'b1;
            end
            PM_NAP: begin
                ctl.run_sub  = 1'b1;
                ctl.run_aux  = 1'b1;
                ctl.fast_en  = 1'b1;
                ctl.bias_en  = 1'b1;
                ctl.slow_en  = 1'b1;
            end
            PM_NAP_LEAN: begin
                ctl.run_sub  = 1'b1;
                ctl.run_aux  = 1'b1;
                ctl.fast_en  = sub_on_fast;
                ctl.bias_en  = sub_on_fast;
                ctl.slow_en  = 1'b1;
            end
            PM_DOZE: begin
                ctl.run_aux  = 1'b1;
                ctl.bias_en  = 1'b1;
                ctl.slow_en  = 1'b1;
            end
            PM_DOZE_DEEP: begin
                ctl.run_aux  = 1'b1;
                ctl.slow_en  = 1'b1;
            end
            PM_HALT: begin
                ctl = '0;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/clkctl_regs.sv
`timescale 1ns/1ps
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter logic [7:0] A_TUNE = ADR_TUNE,
    parameter logic [7:0] A_CFGA = ADR_CFGA,
    parameter logic [7:0] A_CFGB = ADR_CFGB,
    parameter logic [7:0] A_CFGC = ADR_CFGC
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic [7:0]       addr,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [DIV_W-1:0] main_sel,
    output logic [DIV_W-1:0] main_div,
    output logic             sub_sel,
    output logic [DIV_W-1:0] sub_div,
    output logic [DIV_W-1:0] aux_div,
    output logic             aux_xtal
);
    logic [7:0] tune_q;
    logic [7:0] cfga_q;
    logic [7:0] cfgb_q;
    logic [7:0] cfgc_q;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            tune_q <= RST_TUNE;
            cfga_q <= RST_CFGA;
            cfgb_q <= RST_CFGB;
            cfgc_q <= RST_CFGC;
        end else if (wr) begin
            if (addr == A_TUNE) tune_q <= wdata;
            if (addr == A_CFGA) cfga_q <= wdata;
            if (addr == A_CFGB) cfgb_q <= wdata;
            if (addr == A_CFGC) cfgc_q <= wdata;
        end
    end

    always_comb begin
        if (addr == A_TUNE)      rdata = tune_q;
        else if (addr == A_CFGA) rdata = cfga_q;
        else if (addr == A_CFGB) rdata = cfgb_q;
        else if (addr == A_CFGC) rdata = cfgc_q;
        else                     rdata = 8'h00;
    end

    assign main_sel = cfgb_q[7:6];
    assign main_div = cfgb_q[5:4];
    assign sub_sel  = cfgb_q[3];
    assign sub_div  = cfgb_q[2:1];
    assign aux_div  = cfga_q[5:4];
    assign aux_xtal = cfga_q[6];

endmodule

// File: rtl/clkctl_unit.sv
`timescale 1ns/1ps
module clkctl_unit
    import clkctl_pkg::*;
(
    input  logic       pclk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pm_core_off,
    input  logic       pm_bias_off,
    input  logic       pm_sub_off,
    input  logic       pm_osc_off,
    input  logic       fast_osc_clk,
    input  logic       xtal2_clk,
    input  logic       slow_osc_clk,
    output logic       main_clk,
    output logic       sub_clk,
    output logic       aux_clk,
    output logic       fast_osc_en,
    output logic       bias_gen_en,
    output logic       slow_osc_en
);
    logic [DIV_W-1:0] main_sel;
    logic [DIV_W-1:0] main_div;
    logic             sub_sel;
    logic [DIV_W-1:0] sub_div;
    logic [DIV_W-1:0] aux_div;
    logic             aux_xtal;
    pm_ctl_t          pm_ctl;

    logic [NUM_CH-1:0] ch_src;
    logic [NUM_CH-1:0] ch_run;
    logic [NUM_CH-1:0] ch_out;
    logic [DIV_W-1:0]  ch_code [NUM_CH];

    clkctl_regs u_regs (
        .pclk     (pclk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .main_sel (main_sel),
        .main_div (main_div),
        .sub_sel  (sub_sel),
        .sub_div  (sub_div),
        .aux_div  (aux_div),
        .aux_xtal (aux_xtal)
    );

    clkctl_pmode u_pmode (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .core_off    (pm_core_off),
        .bias_off    (pm_bias_off),
        .sub_off     (pm_sub_off),
        .osc_off     (pm_osc_off),
        .sub_on_fast (!sub_sel),
        .ctl         (pm_ctl)
    );

    always_comb begin
        unique case (main_sel)
            2'b10:   ch_src[CH_MAIN] = xtal2_clk;
            2'b11:   ch_src[CH_MAIN] = slow_osc_clk;
            default: ch_src[CH_MAIN] = fast_osc_clk;
        endcase
    end
    assign ch_src[CH_SUB] = sub_sel  ? xtal2_clk : fast_osc_clk;
    assign ch_src[CH_AUX] = aux_xtal ? xtal2_clk : slow_osc_clk;

    assign ch_code[CH_MAIN] = main_div;
    assign ch_code[CH_SUB]  = sub_div;
    assign ch_code[CH_AUX]  = aux_div;

    assign ch_run[CH_MAIN] = pm_ctl.run_main;
    assign ch_run[CH_SUB]  = pm_ctl.run_sub;
    assign ch_run[CH_AUX]  = pm_ctl.run_aux;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clkctl_divgate #(.DIV_W(DIV_W)) u_dg (
            .rst_n    (rst_n),
            .src_clk  (ch_src[g]),
            .div_code (ch_code[g]),
            .run_en   (ch_run[g]),
            .clk_out  (ch_out[g])
        );
    end

    assign main_clk    = ch_out[CH_MAIN];
    assign sub_clk     = ch_out[CH_SUB];
    assign aux_clk     = ch_out[CH_AUX];
    assign fast_osc_en = pm_ctl.fast_en;
    assign bias_gen_en = pm_ctl.bias_en;
    assign slow_osc_en = pm_ctl.slow_en;

endmodule

// File: rtl/clkctl_unit_sva.sv
`timescale 1ns/1ps
module clkctl_unit_sva
    import clkctl_pkg::*;
(
    input logic       pclk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       pm_core_off,
    input logic       pm_bias_off,
    input logic       pm_sub_off,
    input logic       pm_osc_off,
    input logic [1:0] main_sel,
    input logic [1:0] main_div,
    input logic       sub_sel,
    input logic [1:0] sub_div,
    input logic [1:0] aux_div,
    input logic       aux_xtal,
    input logic       fast_osc_en,
    input logic       bias_gen_en,
    input logic       slow_osc_en
);
    logic [9:0] fields;
    assign fields = {main_sel, main_div, sub_sel, sub_div, aux_div, aux_xtal};

    a_r1_cfgb_write: assert property (@(posedge pclk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_CFGB) |=>
            ({main_sel, main_div, sub_sel, sub_div} == $past(bus_wdata[7:1])));

    a_r2_unmapped_write: assert property (@(posedge pclk) disable iff (!rst_n)
        (bus_wr && !addr_mapped(bus_addr)) |=> $stable(fields));

    a_r2_unmapped_read: assert property (@(posedge pclk) disable iff (!rst_n)
        !addr_mapped(bus_addr) |-> (bus_rdata == 8'h00));

    a_r8_run_all_on: assert property (@(posedge pclk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pm_core_off)) |->
            (fast_osc_en && bias_gen_en && slow_osc_en));

    a_r8_halt_all_off: assert property (@(posedge pclk) disable iff (!rst_n)
        ($past(rst_n) && $past(pm_core_off && pm_bias_off && pm_sub_off && pm_osc_off)) |->
            (!fast_osc_en && !bias_gen_en && !slow_osc_en));

    a_r8_doze_bias_kept: assert property (@(posedge pclk) disable iff (!rst_n)
        ($past(rst_n) && $past(pm_core_off && pm_sub_off && !pm_bias_off)) |->
            (!fast_osc_en && bias_gen_en && slow_osc_en));

    a_r8_nap_lean_follows_sub: assert property (@(posedge pclk) disable iff (!rst_n)
        ($past(rst_n) && $past(pm_core_off && pm_bias_off && !pm_sub_off)) |->
            ((fast_osc_en == !sub_sel) && (bias_gen_en == !sub_sel)));

endmodule

bind clkctl_unit clkctl_unit_sva u_sva (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pm_core_off (pm_core_off),
    .pm_bias_off (pm_bias_off),
    .pm_sub_off  (pm_sub_off),
    .pm_osc_off  (pm_osc_off),
    .main_sel    (main_sel),
    .main_div    (main_div),
    .sub_sel     (sub_sel),
    .sub_div     (sub_div),
    .aux_div     (aux_div),
    .aux_xtal    (aux_xtal),
    .fast_osc_en (fast_osc_en),
    .bias_gen_en (bias_gen_en),
    .slow_osc_en (slow_osc_en)
);

// File: tb/clkctl_unit_test.sv
`timescale 1ns/1ps
module clkctl_unit_test;

    logic       pclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pm_core_off = 1'b0;
    logic       pm_bias_off = 1'b0;
    logic       pm_sub_off = 1'b0;
    logic       pm_osc_off = 1'b0;
    logic       fast_osc_clk = 1'b0;
    logic       xtal2_clk = 1'b0;
    logic       slow_osc_clk = 1'b0;
    logic       main_clk, sub_clk, aux_clk;
    logic       fast_osc_en, bias_gen_en, slow_osc_en;

    always #2  pclk = ~pclk;          // 250 MHz
    always #5  fast_osc_clk = ~fast_osc_clk;
    always #7  xtal2_clk = ~xtal2_clk;
    always #20 slow_osc_clk = ~slow_osc_clk;

    clkctl_unit uut (
        .pclk(pclk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pm_core_off(pm_core_off), .pm_bias_off(pm_bias_off),
        .pm_sub_off(pm_sub_off), .pm_osc_off(pm_osc_off),
        .fast_osc_clk(fast_osc_clk), .xtal2_clk(xtal2_clk), .slow_osc_clk(slow_osc_clk),
        .main_clk(main_clk), .sub_clk(sub_clk), .aux_clk(aux_clk),
        .fast_osc_en(fast_osc_en), .bias_gen_en(bias_gen_en), .slow_osc_en(slow_osc_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int edges_main = 0;
    int edges_sub = 0;
    int edges_aux = 0;
    int pending = 0;

    always @(posedge main_clk) edges_main++;
    always @(posedge sub_clk)  edges_sub++;
    always @(posedge aux_clk)  edges_aux++;

    typedef struct {
        int    ch;
        int    per;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge pclk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge pclk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge pclk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_clk(input int ch, input int per, input string tag);
        sb_item_t it;
        it.ch = ch; it.per = per; it.tag = tag;
        sb_q.push_back(it);
        pending++;
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    task automatic set_pm(input logic c, input logic b, input logic s, input logic o);
        @(negedge pclk);
        pm_core_off = c; pm_bias_off = b; pm_sub_off = s; pm_osc_off = o;
        repeat (2) @(negedge pclk);
    endtask

    task automatic chk_en(input string tag, input int f, input int b, input int s);
        chk({tag, " fast_en"}, int'(fast_osc_en), f);
        chk({tag, " bias_en"}, int'(bias_gen_en), b);
        chk({tag, " slow_en"}, int'(slow_osc_en), s);
    endtask

    task automatic wait_rise(input int ch);
        case (ch)
            0: @(posedge main_clk);
            1: @(posedge sub_clk);
            default: @(posedge aux_clk);
        endcase
    endtask

    function automatic int edges_of(input int ch);
        case (ch)
            0: return edges_main;
            1: return edges_sub;
            default: return edges_aux;
        endcase
    endfunction

    function automatic int level_of(input int ch);
        case (ch)
            0: return int'(main_clk);
            1: return int'(sub_clk);
            default: return int'(aux_clk);
        endcase
    endfunction

    // monitor: pops expectations and measures the output clock
    initial begin
        forever begin
            sb_item_t it;
            wait (pending > 0);
            it = sb_q.pop_front();
            if (it.per == 0) begin
                int e0;
                #800;
                e0 = edges_of(it.ch);
                chk({it.tag, " level low"}, level_of(it.ch), 0);
                #1000;
                chk({it.tag, " no edges"}, edges_of(it.ch) - e0, 0);
                chk({it.tag, " still low"}, level_of(it.ch), 0);
            end else begin
                time t0, t1;
                repeat (4) wait_rise(it.ch);
                t0 = $time;
                wait_rise(it.ch);
                t1 = $time;
                chk({it.tag, " period"}, int'(t1 - t0), it.per);
            end
            pending--;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #600000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge pclk);
        rst_n = 1'b1;
        repeat (2) @(negedge pclk);

        // R1 reset values
        rd(8'h56, d); chk("R1 reset tune", d, 8'h60);
        rd(8'h57, d); chk("R1 reset cfga", d, 8'h87);
        rd(8'h58, d); chk("R1 reset cfgb", d, 8'h00);
        rd(8'h53, d); chk("R1 reset cfgc", d, 8'h05);
        chk_en("R8 run after reset", 1, 1, 1);

        // R3 R5 R6 defaults: fast/1, fast/1, slow/1
        expect_clk(0, 10, "R3 main default fast/1");
        expect_clk(1, 10, "R5 sub default fast/1");
        expect_clk(2, 40, "R6 aux default slow/1");
        drain();

        // R2 unmapped accesses
        wr(8'h59, 8'h55);
        wr(8'h00, 8'hFF);
        rd(8'h59, d); chk("R2 unmapped read 0x59", d, 8'h00);
        rd(8'h00, d); chk("R2 unmapped read 0x00", d, 8'h00);
        rd(8'h56, d); chk("R2 tune untouched", d, 8'h60);
        rd(8'h57, d); chk("R2 cfga untouched", d, 8'h87);
        rd(8'h58, d); chk("R2 cfgb untouched", d, 8'h00);
        rd(8'h53, d); chk("R2 cfgc untouched", d, 8'h05);

        // R1 write and read back
        wr(8'h56, 8'hA5); rd(8'h56, d); chk("R1 tune readback", d, 8'hA5);
        wr(8'h53, 8'h3C); rd(8'h53, d); chk("R1 cfgc readback", d, 8'h3C);

        // R3 R4 main source and ratio
        wr(8'h58, 8'b01_01_0000); expect_clk(0, 20, "R3 R4 main code01 fast/2"); drain();
        wr(8'h58, 8'b10_10_0000); expect_clk(0, 56, "R3 R4 main xtal2/4"); drain();
        wr(8'h58, 8'b11_11_0000); expect_clk(0, 320, "R3 R4 main slow/8"); drain();
        wr(8'h58, 8'b00_11_0000); expect_clk(0, 80, "R4 main fast/8"); drain();

        // R5 sub source and ratio
        wr(8'h58, 8'b0000_1_01_0);
        expect_clk(1, 28, "R5 sub xtal2/2");
        expect_clk(0, 10, "R4 main back to fast/1");
        drain();
        wr(8'h58, 8'b0000_0_11_0); expect_clk(1, 80, "R5 sub fast/8"); drain();

        // R6 aux ratio and source
        wr(8'h57, 8'hA7); expect_clk(2, 160, "R6 aux slow/4"); drain();
        wr(8'h57, 8'hD7); expect_clk(2, 28, "R6 aux xtal2/2"); drain();
        wr(8'h57, 8'h87);
        wr(8'h58, 8'h00);

        // R7 R8 R9 power modes
        set_pm(1, 0, 0, 0);
        chk_en("R8 nap", 1, 1, 1);
        expect_clk(0, 0, "R7 R9 nap main stopped");
        expect_clk(1, 10, "R7 nap sub runs");
        drain();

        set_pm(1, 1, 0, 0);
        chk_en("R8 nap_lean sub on fast", 1, 1, 1);
        wr(8'h58, 8'h08);
        repeat (2) @(negedge pclk);
        chk_en("R8 nap_lean sub on xtal2", 0, 0, 1);
        expect_clk(1, 14, "R7 nap_lean sub xtal2/1");
        drain();
        wr(8'h58, 8'h00);

        set_pm(1, 0, 1, 0);
        chk_en("R8 doze", 0, 1, 1);
        expect_clk(1, 0, "R7 R9 doze sub stopped");
        expect_clk(2, 40, "R7 doze aux runs");
        drain();

        set_pm(1, 1, 1, 0);
        chk_en("R8 doze_deep", 0, 0, 1);
        expect_clk(2, 40, "R7 doze_deep aux runs");
        drain();

        set_pm(1, 1, 1, 1);
        chk_en("R8 halt", 0, 0, 0);
        expect_clk(2, 0, "R7 R9 halt aux stopped");
        expect_clk(0, 0, "R7 R9 halt main stopped");
        drain();

        set_pm(0, 0, 0, 0);
        chk_en("R8 back to run", 1, 1, 1);
        expect_clk(0, 10, "R9 main resumes");
        expect_clk(1, 10, "R9 sub resumes");
        expect_clk(2, 40, "R9 aux resumes");
        drain();

        finish_run();
    end

endmodule